// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block drives the system reset for a processor complex. It is built from three cooperating parts. The first holds reset for a fixed stretch after power-on. The second keeps reset asserted while an external comparator reports a low supply, and adds the same stretch once the supply has recovered. The third is a watchdog. If software stops toggling the chip-select pin within the selected window, the watchdog forces a new reset pulse. All timing is counted in units of `tick_i`, a one-cycle pulse from a prescaler. In production that pulse occurs once per millisecond, which makes the default stretch 200 ms and the windows 0.2 s, 0.6 s and 1.4 s.

Software configures the watchdog over a mode 0 SPI slave: SCK idles low, data is sampled on the rising edge and shifted out on the falling edge. The active-low chip-select line does double duty as the watchdog kick. Every edge on it, whether from a real transfer or a bare pulse, restarts the watchdog count. A change to the timeout selection is only accepted after a separate command has set a write-enable latch. The selection sits in a register that `rst_ni` does not clear, which models a setting held in nonvolatile storage.

All SPI pins are oversampled in the `clk_i` domain through two-flop synchronisers. SCK must therefore stay in each level for at least four `clk_i` cycles.

Top module: `supv_ctrl`

## Requirements
- R1: `sys_rst_o` is 1 while `rst_ni` is low, and stays 1 for exactly `STRETCH_TICKS` ticks after `rst_ni` is released.
- R2: While `supply_low_i` is 1 (after a two-flop synchroniser), `sys_rst_o` is 1. It falls after exactly `STRETCH_TICKS` ticks counted from the synchronised deassertion.
- R3: Selection 2'b00 fires the watchdog on the `WD_T0_TICKS`-th tick after the count starts, 2'b01 on the `WD_T1_TICKS`-th, and 2'b10 on the `WD_T2_TICKS`-th.
- R4: Selection 2'b11 disables the watchdog, so it never asserts reset.
- R5: Any edge on `cs_wdi_ni` (after synchronisation) restarts the watchdog count from zero.
- R6: A watchdog expiry asserts `sys_rst_o` for exactly `STRETCH_TICKS` ticks. The watchdog count then starts again from zero.
- R7: A status write (opcode 0x01) issued while the write-enable latch is clear leaves the selection unchanged.
- R8: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch state is readable as status bit 1.
- R9: A completed status write with the latch set copies data bits 5:4 into the selection and clears the latch.
- R10: The watchdog selection keeps its value across an `rst_ni` pulse.
- R11: While `sys_rst_o` is 1, SPI commands have no effect, `so_o` stays 0 and the latch is held clear.
- R12: Opcode 0x05 returns the status byte on `so_o`, MSB first, in the byte that follows the opcode. Bits 5:4 hold the selection, bit 1 holds the latch, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle timebase pulse (1 ms in production) |
| supply_low_i | input | 1 | Asynchronous supply-low flag from the comparator |
| sck_i | input | 1 | SPI clock, mode 0 |
| si_i | input | 1 | SPI serial data in |
| cs_wdi_ni | input | 1 | Active-low SPI select, also the watchdog kick |
| so_o | output | 1 | SPI serial data out, 0 when not selected |
| sys_rst_o | output | 1 | Active-high system reset |

## Verification
The bench builds the block with `STRETCH_TICKS`=6 and windows of 5, 9 and 14 ticks, and drives one tick every 64 clocks. With these values every timeout, the stretch after each reset cause, and the full silence of the off setting can be measured tick by tick within a short run. The shortest window still exceeds a two-byte SPI transfer, so configuration traffic finishes before the watchdog can fire. The persistence, latch-protection and reset-ignore cases are observed purely through status reads and the reset pin.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_RDSR = 8'h05;

  localparam logic [1:0] WD_SEL_OFF = 2'b11;

  typedef enum logic [1:0] {
    ST_OPC   = 2'd0,
    ST_WDATA = 2'd1,
    ST_RDATA = 2'd2,
    ST_SKIP  = 2'd3
  } cmd_st_e;
endpackage

// File: rtl/supv_spi_port.sv
module supv_spi_port
  import supv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              cs_ni,
  output logic              cs_act_o,
  output logic              kick_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              so_o
);
  logic [2:0] sck_q, cs_q;
  logic [1:0] si_q;
  logic       sck_rise, sck_fall, si_s;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              first_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      cs_q  <= {cs_q[1:0], cs_ni};
      si_q  <= {si_q[0], si_i};
    end
  end

  assign cs_act_o = ~cs_q[1];
  assign kick_o   = cs_q[1] ^ cs_q[2];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign si_s     = si_q[1];

  assign byte_vld_o = cs_act_o & sck_rise & (bit_cnt == BIT_W'(BYTE_W - 1));
  assign byte_o     = {rx_sh, si_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      first_fall <= 1'b1;
    end else if (!cs_act_o) begin
      bit_cnt    <= '0;
      tx_sh      <= '0;
      first_fall <= 1'b1;
    end else begin
      if (sck_rise) begin
        rx_sh   <= {rx_sh[BYTE_W-3:0], si_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      // the fall that closes a byte must not shift: it exposes the new MSB
      if (byte_vld_o) first_fall <= 1'b1;
      else if (sck_fall) first_fall <= 1'b0;
      if (tx_load_i) tx_sh <= tx_data_i;
      else if (sck_fall && !first_fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  assign so_o = cs_act_o & tx_sh[BYTE_W-1];
endmodule

// File: rtl/supv_cmd.sv
module supv_cmd
  import supv_pkg::*;
#(
  parameter logic [1:0] WD_INIT = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              cs_act_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              wel_o,
  output logic [1:0]        wd_sel_o
);
  cmd_st_e    st_q;
  logic       wel_q;
  logic [1:0] wd_sel_q = WD_INIT;  // retained: not touched by rst_ni
  logic       live, wr_commit;

  assign live      = !sys_rst_i && cs_act_i && byte_vld_i;
  assign wr_commit = live && (st_q == ST_WDATA) && wel_q;
  assign tx_load_o = live && ((st_q == ST_RDATA) ||
                              ((st_q == ST_OPC) && (byte_i == OPC_RDSR)));
  assign tx_data_o = {2'b00, wd_sel_q, 2'b00, wel_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OPC;
      wel_q <= 1'b0;
    end else if (sys_rst_i) begin
      st_q  <= ST_OPC;
      wel_q <= 1'b0;
    end else if (!cs_act_i) begin
      st_q <= ST_OPC;
    end else if (byte_vld_i) begin
      unique case (st_q)
        ST_OPC: begin
          unique case (byte_i)
            OPC_WREN: begin wel_q <= 1'b1; st_q <= ST_SKIP; end
            OPC_WRDI: begin wel_q <= 1'b0; st_q <= ST_SKIP; end
            OPC_WRSR: st_q <= ST_WDATA;
            OPC_RDSR: st_q <= ST_RDATA;
            default:  st_q <= ST_SKIP;
          endcase
        end
        ST_WDATA: begin
          if (wel_q) wel_q <= 1'b0;
          st_q <= ST_SKIP;
        end
        ST_RDATA: st_q <= ST_RDATA;
        default:  st_q <= ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_commit) wd_sel_q <= byte_i[5:4];
  end

  assign wel_o    = wel_q;
  assign wd_sel_o = wd_sel_q;
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int unsigned T0   = 200,
  parameter int unsigned T1   = 600,
  parameter int unsigned T2   = 1400,
  parameter int unsigned CW   = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sys_rst_i,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  logic [CW-1:0] cnt_q, lim_m1;
  logic          en, at_end;

  always_comb begin
    unique case (sel_i)
      2'b00:   lim_m1 = CW'(T0 - 1);
      2'b01:   lim_m1 = CW'(T1 - 1);
      default: lim_m1 = CW'(T2 - 1);
    endcase
  end

  assign en     = (sel_i != WD_SEL_OFF);
  // >= covers a switch to a shorter window mid-count
  assign at_end = (cnt_q >= lim_m1);
  assign fire_o = en && !sys_rst_i && !kick_i && tick_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (sys_rst_i || kick_i || !en) cnt_q <= '0;
    else if (tick_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/supv_rstgen.sv
module supv_rstgen #(
  parameter int unsigned STRETCH = 200,
  parameter int unsigned CW      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic low_i,
  input  logic wd_fire_i,
  output logic low_s_o,
  output logic sys_rst_o
);
  logic [1:0]    low_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 2'b11;
    else         low_q <= {low_q[0], low_i};
  end
  assign low_s_o = low_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (low_s_o || wd_fire_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick_i) begin
      if (cnt_q == CW'(STRETCH - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sys_rst_o = act_q;
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
#(
  parameter int unsigned STRETCH_TICKS = 200,
  parameter int unsigned WD_T0_TICKS   = 200,
  parameter int unsigned WD_T1_TICKS   = 600,
  parameter int unsigned WD_T2_TICKS   = 1400,
  parameter logic [1:0]  WD_INIT       = 2'b00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic cs_wdi_ni,
  output logic so_o,
  output logic sys_rst_o
);
  localparam int unsigned WD_MAX01 = (WD_T0_TICKS > WD_T1_TICKS) ? WD_T0_TICKS : WD_T1_TICKS;
  localparam int unsigned WD_MAX   = (WD_MAX01 > WD_T2_TICKS) ? WD_MAX01 : WD_T2_TICKS;
  localparam int unsigned WD_W     = $clog2(WD_MAX + 1);
  localparam int unsigned ST_W     = $clog2(STRETCH_TICKS + 1);

  logic              cs_act, kick, byte_vld, tx_load, wel, wd_fire, low_sync;
  logic [BYTE_W-1:0] rx_byte, tx_data;
  logic [1:0]        wd_sel;

  supv_spi_port u_spi (
    .clk_i, .rst_ni, .sck_i, .si_i, .cs_ni(cs_wdi_ni),
    .cs_act_o(cs_act), .kick_o(kick), .byte_vld_o(byte_vld), .byte_o(rx_byte),
    .tx_load_i(tx_load), .tx_data_i(tx_data), .so_o
  );

  supv_cmd #(.WD_INIT(WD_INIT)) u_cmd (
    .clk_i, .rst_ni, .sys_rst_i(sys_rst_o), .cs_act_i(cs_act),
    .byte_vld_i(byte_vld), .byte_i(rx_byte), .tx_load_o(tx_load),
    .tx_data_o(tx_data), .wel_o(wel), .wd_sel_o(wd_sel)
  );

  supv_wdog #(.T0(WD_T0_TICKS), .T1(WD_T1_TICKS), .T2(WD_T2_TICKS), .CW(WD_W)) u_wdog (
    .clk_i, .rst_ni, .tick_i, .sys_rst_i(sys_rst_o), .kick_i(kick),
    .sel_i(wd_sel), .fire_o(wd_fire)
  );

  supv_rstgen #(.STRETCH(STRETCH_TICKS), .CW(ST_W)) u_rst (
    .clk_i, .rst_ni, .tick_i, .low_i(supply_low_i), .wd_fire_i(wd_fire),
    .low_s_o(low_sync), .sys_rst_o
  );
endmodule

// File: rtl/supv_ctrl_chk.sv
module supv_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       sys_rst_o,
  input logic       low_s_i,
  input logic       wd_fire_i,
  input logic       wel_i,
  input logic [1:0] wd_sel_i
);
  a_r2_low_holds_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_s_i |=> sys_rst_o);
  a_r1_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> ($past(tick_i) && !$past(low_s_i)));
  a_r4_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == 2'b11) |-> !wd_fire_i);
  a_r6_fire_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire_i |=> sys_rst_o);
  a_r7_sel_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wd_sel_i) |-> $past(wel_i));
  a_r9_wel_autoclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wd_sel_i) |-> !wel_i);
  a_r11_no_fire_in_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !wd_fire_i);
endmodule

bind supv_ctrl supv_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sys_rst_o(sys_rst_o),
  .low_s_i(low_sync), .wd_fire_i(wd_fire), .wel_i(wel), .wd_sel_i(wd_sel)
);

// File: tb/sim_supv_ctrl.sv
`timescale 1ns/1ps
module sim_supv_ctrl;
  localparam int ST = 6, T0 = 5, T1 = 9, T2 = 14;
  localparam int TICK_DIV = 64, HALF = 4;
  localparam int NVEC = 4;
  localparam logic [1:0] VSEL [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         VEXP [NVEC] = '{T0, T1, T2, 0};

  logic clk = 0, rst_ni = 0, tick = 0, low = 0, sck = 0, si = 0, cs_n = 1;
  logic so, sys_rst;
  int   n_chk = 0, n_err = 0, tdiv = 0;
  logic [7:0] rd;
  int   n;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  supv_ctrl #(.STRETCH_TICKS(ST), .WD_T0_TICKS(T0), .WD_T1_TICKS(T1),
              .WD_T2_TICKS(T2), .WD_INIT(2'b00)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .supply_low_i(low),
    .sck_i(sck), .si_i(si), .cs_wdi_ni(cs_n), .so_o(so), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic cmd(input logic [7:0] op, input bit two, input logic [7:0] d,
                     output logic [7:0] r);
    logic [7:0] dummy;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    spi_byte(op, dummy);
    r = 8'h00;
    if (two) spi_byte(d, r);
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  // stop on the negedge just after a tick, far from the next one
  task automatic tick_gap();
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic count_while(input logic lvl, input int lim, output int cnt);
    cnt = 0;
    for (int c = 0; c < lim; c++) begin
      if (sys_rst != lvl) break;
      if (tick) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rel();
    @(negedge clk);
    while (sys_rst) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 power-on stretch
    repeat (5) @(negedge clk);
    chk("R1 rst during rst_ni", sys_rst, 1);
    tick_gap();
    rst_ni = 1;
    count_while(1'b1, 40 * TICK_DIV, n);
    chk("R1 stretch ticks", n, ST);

    for (int v = 0; v < NVEC; v++) begin
      wait_rel();
      cmd(8'h06, 0, 8'h00, rd);
      cmd(8'h05, 1, 8'h00, rd);
      chk("R8 latch set bit1", rd[1], 1);
      cmd(8'h01, 1, {2'b00, VSEL[v], 4'h0}, rd);
      cmd(8'h05, 1, 8'h00, rd);
      chk("R12 status byte", rd, {2'b00, VSEL[v], 4'h0});
      chk("R9 latch cleared", rd[1], 0);
      low = 1;
      repeat (8) @(negedge clk);
      chk("R2 rst while low", sys_rst, 1);
      tick_gap();
      low = 0;
      count_while(1'b1, 40 * TICK_DIV, n);
      chk("R2 stretch after low", n, ST);
      count_while(1'b0, 4 * T2 * TICK_DIV, n);
      if (VEXP[v] == 0) begin
        chk("R4 off no reset", sys_rst, 0);
      end else begin
        chk("R3 timeout ticks", n, VEXP[v]);
        count_while(1'b1, 40 * TICK_DIV, n);
        chk("R6 stretch after fire", n, ST);
      end
    end

    // R7 write without latch
    cmd(8'h01, 1, 8'h00, rd);
    cmd(8'h05, 1, 8'h00, rd);
    chk("R7 sel kept", rd, 8'h30);

    // R8 latch cleared by 0x04 blocks the write
    cmd(8'h06, 0, 8'h00, rd);
    cmd(8'h04, 0, 8'h00, rd);
    cmd(8'h01, 1, 8'h00, rd);
    cmd(8'h05, 1, 8'h00, rd);
    chk("R8 disable blocks write", rd, 8'h30);

    // R10 retention across rst_ni
    cmd(8'h06, 0, 8'h00, rd);
    cmd(8'h01, 1, 8'h20, rd);
    @(negedge clk);
    rst_ni = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    wait_rel();
    cmd(8'h05, 1, 8'h00, rd);
    chk("R10 sel after rst_ni", rd, 8'h20);

    // R11 commands ignored during reset
    low = 1;
    repeat (8) @(negedge clk);
    cmd(8'h05, 1, 8'h00, rd);
    chk("R11 so low in reset", rd, 8'h00);
    cmd(8'h06, 0, 8'h00, rd);
    cmd(8'h01, 1, 8'h30, rd);
    low = 0;
    wait_rel();
    cmd(8'h05, 1, 8'h00, rd);
    chk("R11 sel unchanged", rd, 8'h20);

    // R5 kicks on cs_wdi_ni keep the shortest window from expiring
    cmd(8'h06, 0, 8'h00, rd);
    cmd(8'h01, 1, 8'h00, rd);
    n = 0;
    for (int k = 0; k < 15; k++) begin
      for (int c = 0; c < 3 * TICK_DIV; c++) begin
        if (sys_rst) n++;
        @(negedge clk);
      end
      cs_n = 0;
      repeat (4) @(negedge clk);
      cs_n = 1;
    end
    chk("R5 kicked no reset", n, 0);
    count_while(1'b0, 4 * T0 * TICK_DIV, n);
    chk("R5 fires once kicks stop", sys_rst, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule